// File: doc/BRIEF.md
# Serial Image Auto-Loader with Checksum Verification

After a master reset, this block fills a device's internal registers and RAM from an image held in a byte-wide serial memory. It asks an external byte engine for one byte at a time. It joins each pair of bytes into a 16-bit word, writes that word to the matching internal location, and reads the word back at once to confirm that it was stored. A 16-bit running sum over the image has to come out at zero. The image's stored checksum slot makes this possible. A few volatile registers are left out of the sum.

When the last word has been handled, READY rises. The block then writes the stored checksum into its RAM slot. If anything went wrong, it also raises an interrupt, marks the failure cause in the status word, sets a load-fail bit in the self-test word, and records where the first read-back mismatch happened. A range-select input picks either a short image or the full address space. A lock input decides whether the terminal-address field of the status word comes from pins latched at reset or from the image.

Top module: `ee_autoload`

## Requirements
- R1: Word N is built as {byte at memory address 2N, byte at 2N+1}, so the even byte is the upper half. The word is written to word address N.
- R2: The range input is sampled when a load starts. When it is high, word addresses 0 to 2^SMALL_AW-1 are loaded. When it is low, addresses 0 to 2^WORD_AW-1 are loaded. No word outside the selected range is written during the load.
- R3: Every loaded word is added into a 16-bit sum, except the words at addresses 0x02, 0x06, 0x08 and 0x14. The value in the checksum slot 0x20 is included. A sum other than zero at the end sets the checksum-fail output.
- R4: During the load, 0x0000 is written to address 0x20. After READY rises, the stored checksum word is written there.
- R5: Each word is read back in the cycle after it is written, at the same address. A value that differs from the written value sets the read-back-fail output once READY is high.
- R6: On a read-back failure, the address of the first failing word is written to address 0x1F after READY. Later mismatches do not replace it.
- R7: READY is low until every word in range has been written and checked. Once high, it stays high until the next master reset.
- R8: On any failure, at READY the interrupt goes high and address 0x02 is rewritten with bit 1 set for a checksum failure and bit 0 set for a read-back failure. Address 0x14 is rewritten with bit 15 set. With no failure, the interrupt stays low and addresses 0x02, 0x14 and 0x1F are not written after READY.
- R9: The lock input and the 6-bit pin value are latched when a load starts. With lock high, bits 15:10 of the word written to address 0x02 are the latched pins. With lock low, the loaded word is written unchanged.
- R10: A master reset at any point drops READY, the interrupt and the flags, clears the sum, and restarts the load from memory address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| ee1k_i | input | 1 | Range select: high for the short image |
| lock_i | input | 1 | High keeps the latched pin address in the status word |
| pin_rta_i | input | 6 | Terminal address pins and parity |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | WORD_AW+1 | Byte address |
| mem_ack_i | input | 1 | Byte valid on mem_data_i |
| mem_data_i | input | 8 | Returned byte |
| wr_en_o | output | 1 | Word write strobe |
| rd_en_o | output | 1 | Word read strobe; data is returned one cycle later |
| w_addr_o | output | WORD_AW | Word address |
| w_data_o | output | 16 | Write data |
| rd_data_i | input | 16 | Read data |
| ready_o | output | 1 | Load complete |
| irq_o | output | 1 | Load error interrupt |
| cksum_fail_o | output | 1 | Checksum did not sum to zero |
| rb_fail_o | output | 1 | A read-back mismatch occurred |

## Verification
The bench builds the block with WORD_AW=7 and SMALL_AW=6. That gives a 128-word full range and a 64-word short range, so both range settings run to completion in about a thousand cycles each. Both ranges still contain the checksum slot, the excluded registers and the fail-address register. With these values the bench can reach the end-of-range boundary, the word just past the short range, and read-back faults both before and after the checksum slot.

// File: rtl/ee_al_pkg.sv
package ee_al_pkg;

  typedef enum logic [3:0] {
    S_INIT, S_RD_HI, S_RD_LO, S_WR, S_RB, S_CMP,
    S_FIN, S_P_CK, S_P_STAT, S_P_BIT, S_P_FA, S_DONE
  } seq_e;

  localparam int unsigned ADDR_STAT  = 'h02;
  localparam int unsigned ADDR_BIT   = 'h14;
  localparam int unsigned ADDR_FAIL  = 'h1F;
  localparam int unsigned ADDR_CK    = 'h20;
  localparam int unsigned N_EXCL     = 4;
  localparam int unsigned EXCL_ADDR [N_EXCL] = '{'h02, 'h06, 'h08, 'h14};

endpackage

// File: rtl/ee_al_tally.sv
module ee_al_tally
  import ee_al_pkg::*;
#(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   word,
  output logic          zero_o
);

  logic [15:0] sum_q, sum_d;
  logic        is_excl;

  always_comb begin
    is_excl = 1'b0;
    for (int k = 0; k < N_EXCL; k++) begin
      if (addr == AW'(EXCL_ADDR[k])) is_excl = 1'b1;
    end
  end

  always_comb begin
    sum_d = sum_q;
    if (add_en && !is_excl) sum_d = sum_q + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign zero_o = (sum_q == 16'h0000);

  AST_EXCL_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && is_excl) |=> (sum_q == $past(sum_q))); // R3

endmodule

// File: rtl/ee_al_rbchk.sv
module ee_al_rbchk #(
  parameter int unsigned AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   expect_val,
  input  logic [15:0]   got_val,
  output logic          fail_o,
  output logic [AW-1:0] fail_addr_o
);

  logic          fail_q;
  logic [AW-1:0] fail_addr_q;
  logic          mismatch;
  logic          log_en;

  assign mismatch = cmp_en && (expect_val != got_val);
  assign log_en   = mismatch && !fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      if (mismatch) fail_q <= 1'b1;
      if (log_en)   fail_addr_q <= addr;
    end
  end

  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> $stable(fail_addr_q)); // R6

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> fail_q); // R5

endmodule

// File: rtl/ee_autoload.sv
module ee_autoload
  import ee_al_pkg::*;
#(
  parameter int unsigned WORD_AW  = 15,
  parameter int unsigned SMALL_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ee1k_i,
  input  logic               lock_i,
  input  logic [5:0]         pin_rta_i,
  output logic               mem_req_o,
  output logic [WORD_AW:0]   mem_addr_o,
  input  logic               mem_ack_i,
  input  logic [7:0]         mem_data_i,
  output logic               wr_en_o,
  output logic               rd_en_o,
  output logic [WORD_AW-1:0] w_addr_o,
  output logic [15:0]        w_data_o,
  input  logic [15:0]        rd_data_i,
  output logic               ready_o,
  output logic               irq_o,
  output logic               cksum_fail_o,
  output logic               rb_fail_o
);

  localparam logic [WORD_AW-1:0] FULL_LAST  = '1;
  localparam logic [WORD_AW-1:0] SMALL_LAST = WORD_AW'((64'd1 << SMALL_AW) - 64'd1);
  localparam logic [WORD_AW-1:0] A_STAT = WORD_AW'(ADDR_STAT);
  localparam logic [WORD_AW-1:0] A_BIT  = WORD_AW'(ADDR_BIT);
  localparam logic [WORD_AW-1:0] A_FAIL = WORD_AW'(ADDR_FAIL);
  localparam logic [WORD_AW-1:0] A_CK   = WORD_AW'(ADDR_CK);

  // reset: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  seq_e               state_q, state_d;
  logic [WORD_AW-1:0] idx_q;
  logic [7:0]         hi_q;
  logic [15:0]        word_q, ck_q, stat_q, bit_q;
  logic [5:0]         pins_q;
  logic               lock_q, small_q, ready_q, irq_q, ckf_q;
  logic               tally_zero, rbf;
  logic [WORD_AW-1:0] fail_addr;
  logic               is_last;
  logic [15:0]        wr_val;
  logic               latch_en, hi_en, word_en, idx_en, fin_en, cap_en;

  // value committed to the word port for the current index
  always_comb begin
    wr_val = word_q;
    if (idx_q == A_CK)                wr_val = 16'h0000;
    else if (idx_q == A_STAT && lock_q) wr_val = {pins_q, word_q[9:0]};
  end

  assign is_last = small_q ? (idx_q == SMALL_LAST) : (idx_q == FULL_LAST);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_INIT:   state_d = S_RD_HI;
      S_RD_HI:  if (mem_ack_i) state_d = S_RD_LO;
      S_RD_LO:  if (mem_ack_i) state_d = S_WR;
      S_WR:     state_d = S_RB;
      S_RB:     state_d = S_CMP;
      S_CMP:    state_d = is_last ? S_FIN : S_RD_HI;
      S_FIN:    state_d = S_P_CK;
      S_P_CK:   state_d = irq_q ? S_P_STAT : S_DONE;
      S_P_STAT: state_d = S_P_BIT;
      S_P_BIT:  state_d = rbf ? S_P_FA : S_DONE;
      S_P_FA:   state_d = S_DONE;
      default:  state_d = S_DONE;
    endcase
  end

  assign latch_en = (state_q == S_INIT);
  assign hi_en    = (state_q == S_RD_HI) && mem_ack_i;
  assign word_en  = (state_q == S_RD_LO) && mem_ack_i;
  assign idx_en   = (state_q == S_CMP) && !is_last;
  assign fin_en   = (state_q == S_FIN);
  assign cap_en   = (state_q == S_WR);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_INIT;
      idx_q   <= '0;
      hi_q    <= '0;
      word_q  <= '0;
      ck_q    <= '0;
      stat_q  <= '0;
      bit_q   <= '0;
      pins_q  <= '0;
      lock_q  <= 1'b0;
      small_q <= 1'b0;
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
      ckf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        pins_q  <= pin_rta_i;
        lock_q  <= lock_i;
        small_q <= ee1k_i;
        idx_q   <= '0;
      end else if (idx_en) begin
        idx_q <= idx_q + 1'b1;
      end
      if (hi_en)   hi_q   <= mem_data_i;
      if (word_en) word_q <= {hi_q, mem_data_i};
      if (cap_en && idx_q == A_CK)   ck_q   <= word_q;
      if (cap_en && idx_q == A_STAT) stat_q <= wr_val;
      if (cap_en && idx_q == A_BIT)  bit_q  <= word_q;
      if (fin_en) begin
        ready_q <= 1'b1;
        irq_q   <= !tally_zero || rbf;
        ckf_q   <= !tally_zero;
      end
    end
  end

  ee_al_tally #(.AW(WORD_AW)) u_tally (
    .clk    (clk),
    .rst_n  (rst_s),
    .add_en (cap_en),
    .addr   (idx_q),
    .word   (word_q),
    .zero_o (tally_zero)
  );

  ee_al_rbchk #(.AW(WORD_AW)) u_rbchk (
    .clk         (clk),
    .rst_n       (rst_s),
    .cmp_en      (state_q == S_CMP),
    .addr        (idx_q),
    .expect_val  (wr_val),
    .got_val     (rd_data_i),
    .fail_o      (rbf),
    .fail_addr_o (fail_addr)
  );

  // port drive
  always_comb begin
    mem_req_o  = (state_q == S_RD_HI) || (state_q == S_RD_LO);
    mem_addr_o = {idx_q, state_q == S_RD_LO};
    wr_en_o    = 1'b0;
    rd_en_o    = (state_q == S_RB);
    w_addr_o   = idx_q;
    w_data_o   = wr_val;
    unique case (state_q)
      S_WR:     wr_en_o = 1'b1;
      S_P_CK:   begin wr_en_o = 1'b1; w_addr_o = A_CK;   w_data_o = ck_q; end
      S_P_STAT: begin wr_en_o = 1'b1; w_addr_o = A_STAT; w_data_o = stat_q | {14'b0, ckf_q, rbf}; end
      S_P_BIT:  begin wr_en_o = 1'b1; w_addr_o = A_BIT;  w_data_o = bit_q | 16'h8000; end
      S_P_FA:   begin wr_en_o = 1'b1; w_addr_o = A_FAIL; w_data_o = 16'(fail_addr); end
      default:  ;
    endcase
  end

  assign ready_o      = ready_q;
  assign irq_o        = irq_q;
  assign cksum_fail_o = ckf_q;
  assign rb_fail_o    = ready_q && rbf;

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    ready_o |=> ready_o); // R7

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_s)
    irq_o |-> (ready_o && (cksum_fail_o || rb_fail_o))); // R8

  AST_RB_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_s)
    rd_en_o |-> ($past(wr_en_o) && ($past(w_addr_o) == w_addr_o))); // R5

  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en_o && !ready_o && small_q) |-> (w_addr_o <= SMALL_LAST)); // R2

  AST_CK_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_en_o && !ready_o && w_addr_o == A_CK) |-> (w_data_o == 16'h0000)); // R4

  AST_NO_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_s)
    ready_o |-> !mem_req_o); // R7

endmodule

// File: tb/ee_autoload_test.sv
`timescale 1ns/1ps
module ee_autoload_test;

  localparam int unsigned WAW = 7;
  localparam int unsigned SAW = 6;
  localparam int unsigned NW  = 1 << WAW;
  localparam int unsigned NS  = 1 << SAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ee1k = 1'b0, lock = 1'b0;
  logic [5:0]     pins = '0;
  logic           mem_req, mem_ack = 1'b0;
  logic [WAW:0]   mem_addr;
  logic [7:0]     mem_data = '0;
  logic           wr_en, rd_en;
  logic [WAW-1:0] w_addr;
  logic [15:0]    w_data, rd_data;
  logic           ready, irq, ckf, rbf;

  logic [7:0]     ee  [2*NW];
  logic [15:0]    ram [NW];
  logic [15:0]    w   [NW];
  logic           flt_en = 1'b0;
  int             flt_a0 = 0, flt_a1 = 0;
  int             n_tests = 0, n_fail = 0;
  logic           done = 1'b0;

  always #4 clk = ~clk;

  ee_autoload #(.WORD_AW(WAW), .SMALL_AW(SAW)) uut (
    .clk(clk), .rst_n(rst_n), .ee1k_i(ee1k), .lock_i(lock), .pin_rta_i(pins),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_data_i(mem_data),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .w_addr_o(w_addr), .w_data_o(w_data), .rd_data_i(rd_data),
    .ready_o(ready), .irq_o(irq), .cksum_fail_o(ckf), .rb_fail_o(rbf)
  );

  // byte memory responder
  always @(negedge clk) begin
    mem_ack  <= mem_req && !mem_ack;
    mem_data <= ee[mem_addr];
  end

  // word RAM with optional read faults
  always @(posedge clk) begin
    if (wr_en) ram[w_addr] <= w_data;
    if (rd_en) rd_data <= ram[w_addr] ^
      ((flt_en && (int'(w_addr) == flt_a0 || int'(w_addr) == flt_a1)) ? 16'h0100 : 16'h0000);
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit excl(int i);
    return (i == 'h02 || i == 'h06 || i == 'h08 || i == 'h14);
  endfunction

  task automatic put_bytes();
    for (int i = 0; i < NW; i++) begin
      ee[2*i]   = w[i][15:8];
      ee[2*i+1] = w[i][7:0];
    end
  endtask

  task automatic build(input int seed, input int n);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < NW; i++) w[i] = 16'((i * 'h3A7) + (seed * 'h1F1)) ^ 16'h5C3;
    for (int i = 0; i < n; i++) if (!excl(i) && i != 'h20) s = s + w[i];
    w['h20] = -s;
    put_bytes();
  endtask

  task automatic wait_ready();
    for (int c = 0; c < 6000 && !ready; c++) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic start(input logic r, input logic l, input logic [5:0] p);
    @(negedge clk);
    rst_n = 1'b0;
    ee1k = r; lock = l; pins = p;
    for (int i = 0; i < NW; i++) ram[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 ready low in reset", 16'(ready), 16'h0);
    chk("R10 irq low in reset", 16'(irq), 16'h0);
    chk("R10 no byte request in reset", 16'(mem_req), 16'h0);
  endtask

  task automatic t_clean_small();
    build(1, NS);
    start(1'b1, 1'b0, 6'h2A);
    wait_ready();
    chk("R7 ready after short load", 16'(ready), 16'h1);
    chk("R1 word 0", ram[0], w[0]);
    chk("R1 big-endian word 10", ram[10], {ee[20], ee[21]});
    chk("R2 last short word", ram[NS-1], w[NS-1]);
    chk("R2 word past short range untouched", ram[NS], 16'hDEAD);
    chk("R4 checksum copied", ram['h20], w['h20]);
    chk("R3 checksum ok", 16'(ckf), 16'h0);
    chk("R8 no irq on clean load", 16'(irq), 16'h0);
    chk("R9 lock low keeps loaded status", ram['h02], w['h02]);
    chk("R8 fail-address slot not rewritten", ram['h1F], w['h1F]);
    chk("R8 self-test word unchanged", ram['h14], w['h14]);
  endtask

  task automatic t_clean_full();
    build(2, NW);
    start(1'b0, 1'b1, 6'h2D);
    wait_ready();
    chk("R2 last full word", ram[NW-1], w[NW-1]);
    chk("R9 lock high uses pins", ram['h02], {6'h2D, w['h02][9:0]});
    chk("R3 full checksum ok", 16'(ckf), 16'h0);
    chk("R5 no read-back fail", 16'(rbf), 16'h0);
  endtask

  task automatic t_excluded();
    build(3, NS);
    w['h06] = w['h06] ^ 16'h7777;
    w['h14] = w['h14] ^ 16'h1234;
    put_bytes();
    start(1'b1, 1'b0, 6'h00);
    wait_ready();
    chk("R3 excluded words leave sum zero", 16'(ckf), 16'h0);
    chk("R3 excluded word still loaded", ram['h06], w['h06]);
    chk("R8 irq stays low", 16'(irq), 16'h0);
  endtask

  task automatic t_bad_sum();
    build(4, NS);
    w[17] = w[17] ^ 16'h0001;
    put_bytes();
    start(1'b1, 1'b0, 6'h00);
    wait_ready();
    chk("R3 checksum fail", 16'(ckf), 16'h1);
    chk("R8 irq on checksum fail", 16'(irq), 16'h1);
    chk("R5 no read-back fail", 16'(rbf), 16'h0);
    chk("R8 status bit1", ram['h02], w['h02] | 16'h0002);
    chk("R8 self-test bit15", ram['h14], w['h14] | 16'h8000);
    chk("R6 fail slot untouched", ram['h1F], w['h1F]);
  endtask

  task automatic t_readback();
    build(5, NS);
    flt_en = 1'b1; flt_a0 = 5; flt_a1 = 40;
    start(1'b1, 1'b0, 6'h00);
    wait_ready();
    flt_en = 1'b0;
    chk("R5 read-back fail", 16'(rbf), 16'h1);
    chk("R3 checksum still ok", 16'(ckf), 16'h0);
    chk("R8 irq on read-back fail", 16'(irq), 16'h1);
    chk("R6 first fail address", ram['h1F], 16'd5);
    chk("R8 status bit0", ram['h02], w['h02] | 16'h0001);
    chk("R8 self-test bit15", ram['h14], w['h14] | 16'h8000);
  endtask

  task automatic t_abort();
    build(6, NS);
    flt_en = 1'b1; flt_a0 = 3; flt_a1 = 3;
    start(1'b1, 1'b0, 6'h00);
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    flt_en = 1'b0;
    @(negedge clk);
    chk("R10 ready low after abort", 16'(ready), 16'h0);
    chk("R10 rb flag cleared", 16'(rbf), 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 50 && !mem_req; c++) @(negedge clk);
    chk("R10 restart at address 0", 16'(mem_addr), 16'h0);
    wait_ready();
    chk("R10 reload completes", 16'(ready), 16'h1);
    chk("R10 clean after restart", 16'(irq), 16'h0);
    chk("R10 checksum slot", ram['h20], w['h20]);
  endtask

  initial begin
    for (int i = 0; i < 2*NW; i++) ee[i] = '0;
    t_reset();
    t_clean_small();
    t_clean_full();
    t_excluded();
    t_bad_sum();
    t_readback();
    t_abort();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule